// File: doc/BRIEF.md
# Matrix Keypad Scanner

This block scans a 4x4 matrix keypad and reports the key being held as a 4-bit hexadecimal digit with a valid flag. The keypad lines have pull-ups, so the block pulls one column line low at a time and reads the four row lines, where a low level means pressed. A clock-enable divider sets how fast the scan runs, so the keypad is polled far slower than the system clock while all logic stays on that one clock.

On each scan tick the block turns the active-high form of the row lines and the selected column into an 8-bit code, with the row in the high nibble and the column in the low nibble. A lookup table, computed at elaboration, maps that code to a digit. On the same tick the block updates its outputs and moves the column select to the next column. A column in which no row is low, or more than one row is low, clears the valid flag for that tick. The last digit stays on the output until another key is decoded.

The keys are laid out by row as `1 2 3 A`, `4 5 6 B`, `7 8 9 C`, `0 F E D`.

Top module: `kpad_scan`

## Requirements
- R1: While reset is high at a clock edge, `col_n_o` becomes 4'b1110, `valid_o` becomes 0 and `hex_o` becomes 0.
- R2: Exactly one bit of `col_n_o` is low in every cycle.
- R3: A scan tick occurs once every `TICK_DIV` clock cycles. The first tick after reset is at the `TICK_DIV`-th rising edge. On each tick the low column bit moves up by one position and wraps from bit 3 to bit 0. Between ticks `col_n_o` holds.
- R4: Column bit 0 is the column holding keys 1, 4, 7, 0, and bit c counts rightward from it. Row bit 0 is the row holding keys 1, 2, 3, A, and bit r counts downward from it. The key at row r, column c is digit 4r+c of the hex string 123A456B789C0FED, counted from the left.
- R5: If exactly one row bit is low at a tick, the lookup code {active-high rows[3:0], one-hot column[3:0]} is decoded. At that edge `hex_o` takes the key's value from R4 and `valid_o` goes to 1.
- R6: If all row bits are high at a tick, `valid_o` goes to 0 and `hex_o` holds its previous value.
- R7: If two or more row bits are low at a tick, `valid_o` goes to 0 and `hex_o` holds its previous value.
- R8: `hex_o` and `valid_o` change only at tick edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| row_n_i | input | 4 | Row lines from the keypad, active low |
| col_n_o | output | 4 | Column drive, active low, one column low at a time |
| hex_o | output | 4 | Last decoded key digit |
| valid_o | output | 1 | High when the column sampled at the last tick showed exactly one pressed row |

## Verification
The assertions assume that the row lines are already synchronous to the clock. They also assume the rows have settled to the column selected during the whole tick period before the sampling edge, since the rows are read on the tick edge itself. The bench models the keypad as a combinational function of `col_n_o` and a pressed-key set. It changes that set only at falling edges. Its random patterns include no key, one key, one key in each of several columns, and two keys in one column. The two-keys-in-one-column case goes outside the usual one-key-per-column assumption on purpose, to show that such a column is rejected.

// File: rtl/kpad_pkg.sv
package kpad_pkg;

    localparam int NROW  = 4;
    localparam int NCOL  = 4;
    localparam int CODE_W = NROW + NCOL;
    localparam int ROM_N  = 1 << CODE_W;

    typedef struct packed {
        logic [3:0] hex;
        logic       valid;
    } kp_out_t;

    // digit printed on the key at row r, column c
    function automatic logic [3:0] key_digit(input logic [1:0] r, input logic [1:0] c);
        logic [3:0] v;
        case ({r, c})
            4'h0: v = 4'h1;  4'h1: v = 4'h2;  4'h2: v = 4'h3;  4'h3: v = 4'hA;
            4'h4: v = 4'h4;  4'h5: v = 4'h5;  4'h6: v = 4'h6;  4'h7: v = 4'hB;
            4'h8: v = 4'h7;  4'h9: v = 4'h8;  4'hA: v = 4'h9;  4'hB: v = 4'hC;
            4'hC: v = 4'h0;  4'hD: v = 4'hF;  4'hE: v = 4'hE;  default: v = 4'hD;
        endcase
        return v;
    endfunction

    // table entry {hit, digit} for an 8-bit {row, column} code
    function automatic logic [4:0] code_entry(input logic [CODE_W-1:0] code);
        logic [NROW-1:0] rows;
        logic [NCOL-1:0] cols;
        logic [1:0]      ri;
        logic [1:0]      ci;
        rows = code[CODE_W-1:NCOL];
        cols = code[NCOL-1:0];
        ri   = '0;
        ci   = '0;
        for (int k = 0; k < NROW; k++) if (rows[k]) ri = 2'(k);
        for (int k = 0; k < NCOL; k++) if (cols[k]) ci = 2'(k);
        if ($countones(rows) == 1 && $countones(cols) == 1)
            return {1'b1, key_digit(ri, ci)};
        return 5'b0;
    endfunction

endpackage

// File: rtl/kpad_tick.sv
module kpad_tick #(
    parameter int DIV = 12000
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == LAST) cnt_d = '0;
    end

    assign tick_o = (cnt_q == LAST);

    always_ff @(posedge clk_i) begin
        if (rst_i) cnt_q <= '0;
        else       cnt_q <= cnt_d;
    end

    generate
        if (DIV > 1) begin : g_gap
            p_tick_gap_r3: assert property (@(posedge clk_i) disable iff (rst_i)
                tick_o |=> !tick_o);
        end
    endgenerate

endmodule

// File: rtl/kpad_ring.sv
module kpad_ring #(
    parameter int NCOL = 4
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            step_i,
    output logic [NCOL-1:0] sel_o
);
    logic [NCOL-1:0] sel_d, sel_q;

    always_comb begin
        sel_d = sel_q;
        if (step_i) sel_d = {sel_q[NCOL-2:0], sel_q[NCOL-1]};
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) sel_q <= NCOL'(1);
        else       sel_q <= sel_d;
    end

    assign sel_o = sel_q;

    p_one_col_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        $countones(sel_q) == 1);

    p_col_hold_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        !step_i |=> $stable(sel_q));

    p_col_wrap_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        step_i && sel_q[NCOL-1] |=> sel_q[0]);

endmodule

// File: rtl/kpad_rom.sv
module kpad_rom
    import kpad_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output logic              hit_o,
    output logic [3:0]        hex_o
);
    logic [4:0] tbl [ROM_N];

    generate
        for (genvar i = 0; i < ROM_N; i++) begin : g_tbl
            assign tbl[i] = code_entry(CODE_W'(i));
        end
    endgenerate

    assign {hit_o, hex_o} = tbl[code_i];

endmodule

// File: rtl/kpad_scan.sv
module kpad_scan
    import kpad_pkg::*;
#(
    parameter int TICK_DIV = 12000
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic [NROW-1:0] row_n_i,
    output logic [NCOL-1:0] col_n_o,
    output logic [3:0]      hex_o,
    output logic            valid_o
);
    logic            tick;
    logic [NCOL-1:0] col_sel;
    logic            rom_hit;
    logic [3:0]      rom_hex;
    logic [CODE_W-1:0] code;
    kp_out_t         out_d, out_q;

    kpad_tick #(.DIV(TICK_DIV)) u_tick (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .tick_o(tick)
    );

    kpad_ring #(.NCOL(NCOL)) u_ring (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .step_i(tick),
        .sel_o (col_sel)
    );

    assign code = {~row_n_i, col_sel};

    kpad_rom u_rom (
        .code_i(code),
        .hit_o (rom_hit),
        .hex_o (rom_hex)
    );

    always_comb begin
        out_d = out_q;
        if (tick) begin
            out_d.valid = rom_hit;
            if (rom_hit) out_d.hex = rom_hex;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) out_q <= '0;
        else       out_q <= out_d;
    end

    assign col_n_o = ~col_sel;
    assign hex_o   = out_q.hex;
    assign valid_o = out_q.valid;

    p_out_hold_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        !tick |=> $stable(hex_o) && $stable(valid_o));

    p_idle_clear_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        tick && (&row_n_i) |=> !valid_o && $stable(hex_o));

    p_multi_clear_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        tick && ($countones(~row_n_i) > 1) |=> !valid_o && $stable(hex_o));

    p_hit_valid_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        tick && ($countones(~row_n_i) == 1) |=> valid_o);

endmodule

// File: tb/kpad_scan_tb.sv
module kpad_scan_tb;
    localparam int DIV = 4;
    localparam logic [63:0] LAYOUT = 64'h123A456B789C0FED;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] row_n;
    logic [3:0] col_n;
    logic [3:0] hex;
    logic       valid;
    logic [15:0] pressed = '0;   // bit r*4+c

    int total = 0;
    int bad   = 0;

    // reference model state
    int         m_cnt = 0;
    int         m_col = 0;
    logic [3:0] m_hex = '0;
    logic       m_valid = 1'b0;
    string      m_tag = "R1";
    string      force_tag = "";

    always #5 clk = ~clk;

    kpad_scan #(.TICK_DIV(DIV)) u_dut (
        .clk_i  (clk),
        .rst_i  (rst),
        .row_n_i(row_n),
        .col_n_o(col_n),
        .hex_o  (hex),
        .valid_o(valid)
    );

    // keypad: a pressed key pulls its row low when its column is driven low
    always_comb begin
        for (int r = 0; r < 4; r++) begin
            row_n[r] = 1'b1;
            for (int c = 0; c < 4; c++)
                if (pressed[r*4+c] && !col_n[c]) row_n[r] = 1'b0;
        end
    end

    function automatic logic [3:0] digit_of(input int r, input int c);
        return LAYOUT[63-4*(r*4+c) -: 4];
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // advance one clock and check against the model
    task automatic cyc();
        logic [3:0] rows;
        int nr, rr;
        @(negedge clk);
        if (rst) begin
            m_cnt = 0; m_col = 0; m_hex = '0; m_valid = 1'b0;
            chk("R1 col", 32'(col_n), 32'hE);
            chk("R1 valid", 32'(valid), 32'h0);
            chk("R1 hex", 32'(hex), 32'h0);
            return;
        end
        if (m_cnt == DIV - 1) begin
            m_cnt = 0;
            rows = '0;
            for (int r = 0; r < 4; r++) rows[r] = pressed[r*4+m_col];
            nr = $countones(rows);
            if (nr == 1) begin
                rr = 0;
                for (int r = 0; r < 4; r++) if (rows[r]) rr = r;
                m_hex = digit_of(rr, m_col);
                m_valid = 1'b1;
                m_tag = "R5";
            end else begin
                m_valid = 1'b0;
                m_tag = (nr == 0) ? "R6" : "R7";
            end
            m_col = (m_col + 1) % 4;
        end else begin
            m_cnt++;
            m_tag = "R8";
        end
        if (force_tag != "") m_tag = force_tag;
        chk("R3 col", 32'(col_n), 32'(~(4'b0001 << m_col) & 4'hF));
        chk("R2 onecol", 32'($countones(~col_n)), 32'd1);
        chk({m_tag, " valid"}, 32'(valid), 32'(m_valid));
        chk({m_tag, " hex"}, 32'(hex), 32'(m_hex));
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        int mode, hold, c0;
        void'($urandom(32'd4242));
        run(3);
        @(negedge clk); rst = 1'b0;
        // idle scan, no key: R6
        run(4 * DIV * 2);
        // R4: each key alone, one full scan each
        force_tag = "R4";
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++) begin
                pressed = '0;
                pressed[r*4+c] = 1'b1;
                run(4 * DIV);
            end
        force_tag = "";
        // R6: release, hex must hold
        pressed = '0;
        run(4 * DIV);
        // R7: two rows in column 2
        pressed = '0;
        pressed[0*4+2] = 1'b1;
        pressed[3*4+2] = 1'b1;
        run(4 * DIV * 2);
        // one key in each of two columns
        pressed = '0;
        pressed[1*4+0] = 1'b1;
        pressed[2*4+3] = 1'b1;
        run(4 * DIV * 2);
        // R1: mid-run reset
        @(negedge clk); rst = 1'b1;
        run(2);
        @(negedge clk); rst = 1'b0;
        // note: the two negedges spent toggling rst are modelled by the cyc calls
        // random segments
        for (int s = 0; s < 250; s++) begin
            pressed = '0;
            mode = int'($urandom % 4);
            case (mode)
                1: pressed[$urandom % 16] = 1'b1;
                2: for (int c = 0; c < 4; c++)
                       if ($urandom % 2) pressed[($urandom % 4) * 4 + c] = 1'b1;
                3: begin
                       c0 = int'($urandom % 4);
                       pressed[0*4+c0] = 1'b1;
                       pressed[(1 + $urandom % 3) * 4 + c0] = 1'b1;
                   end
                default: ;
            endcase
            hold = int'($urandom % 40) + 1;
            run(hold);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule